// File: doc/BRIEF.md
# Memory-to-Register Data View Converter

This block takes a data word in memory byte order and turns it into the value a register would hold. For each transfer it can first reverse the bytes of the word, which is needed for big-endian mode, and then rotate the result right by a whole number of bytes. An 8-bit byte-lane select comes with every transfer. Its low half enables result bytes, and every byte that is not enabled comes out as zero. Load, store and coprocessor-transfer data all use this single path.

An unaligned access is sent as two transfers. The first one is flagged as unaligned and carries the reverse and rotate controls, and those controls are applied to both halves. The first half produces no output. Its enabled bytes are held until the second half arrives. The enabled lanes of the second half then fill the byte positions that the first half left empty, and the merged word is produced. There is one register stage: each result appears, with a valid strobe, one clock after the transfer that completes it.

Top module: `dv_mem2reg`

## Requirements
- R1: While reset is asserted and after its release, `valid_o` is 0 and `data_o` is 0 until the first result is produced.
- R2: A transfer with `valid_i`=1 and `unal_i`=0, with no first half pending, sets `valid_o`=1 one clock later, with `data_o` holding its converted value.
- R3: When `swz_i`=1, the word is byte-reversed (byte 0 exchanged with byte 3, byte 1 with byte 2) before it is rotated. When `swz_i`=0 it is not reversed.
- R4: The word is rotated right by `rot_i` bytes (0 to 3): result byte b comes from byte (b+`rot_i`) mod 4 of the input to the rotate.
- R5: Bit b of `lanes_i[3:0]` enables result byte b (bits 8b+7..8b), and every disabled byte is 0. `lanes_i[7:4]` has no effect on the result.
- R6: A transfer with `unal_i`=1 and no first half pending is a first half: `valid_o` is 0 on the next clock.
- R7: The second half of an unaligned access is converted with the reverse and rotate controls of its first half. The `swz_i`, `rot_i` and `unal_i` values of the second half are ignored.
- R8: One clock after the second half, `valid_o`=1. Each byte enabled in the first half keeps its first-half value. Each other byte takes the second-half value if its lane is enabled in the second half, and is 0 otherwise.
- R9: A clock with `valid_i`=0 gives `valid_o`=0 on the next clock. `data_o` changes only when `valid_o` rises with a new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Transfer present this cycle |
| data_i | input | 32 | Data word in memory byte order |
| rot_i | input | 2 | Right-rotate amount in bytes |
| swz_i | input | 1 | Reverse bytes for big-endian mode |
| unal_i | input | 1 | Transfer is the first half of an unaligned access |
| lanes_i | input | 8 | Byte-lane select; the low 4 bits enable result bytes |
| valid_o | output | 1 | Converted word valid |
| data_o | output | 32 | Converted register-view word |

## Verification
Every result is due exactly one clock after the transfer that completes it: one clock after an aligned transfer, or one clock after the second half of an unaligned pair. The cycle after a first half must show no strobe. The bench drives inputs on the falling edge and samples on the next falling edge, after the single register stage has loaded. For an unaligned pair it checks the silent cycle before it drives the second half. The model computes the expected words from the byte-order, rotate, lane and merge rules. Random second halves carry deliberately different control values, so that ignoring them is what gets tested.

// File: rtl/dv_pkg.sv
package dv_pkg;
  typedef struct packed {
    logic       swz;
    logic [1:0] rot;
  } dv_ctl_t;
endpackage

// File: rtl/dv_byte_swap.sv
module dv_byte_swap #(
  parameter int NB = 4
) (
  input  logic            swz_i,
  input  logic [8*NB-1:0] d_i,
  output logic [8*NB-1:0] d_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign d_o[8*b +: 8] = swz_i ? d_i[8*(NB-1-b) +: 8] : d_i[8*b +: 8];
  end
endmodule

// File: rtl/dv_rotate.sv
module dv_rotate #(
  parameter int NB    = 4,
  localparam int RW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [RW-1:0]   rot_i,
  input  logic [8*NB-1:0] d_i,
  output logic [8*NB-1:0] d_o
);
  // NB is a power of two, so the index sum wraps by itself
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [RW-1:0] src;
    assign src = RW'(b) + rot_i;
    assign d_o[8*b +: 8] = d_i[8*src +: 8];
  end
endmodule

// File: rtl/dv_lane_expand.sv
module dv_lane_expand #(
  parameter int NB = 4
) (
  input  logic [NB-1:0]   lane_i,
  output logic [8*NB-1:0] bmask_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign bmask_o[8*b +: 8] = {8{lane_i[b]}};
  end
endmodule

// File: rtl/dv_merge.sv
module dv_merge #(
  parameter int NB  = 4,
  localparam int DW = 8*NB,
  localparam int RW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          unal_i,
  input  logic          swz_i,
  input  logic [RW-1:0] rot_i,
  input  logic [DW-1:0] conv_i,
  input  logic [DW-1:0] bmask_i,
  output logic          pend_o,
  output logic          hswz_o,
  output logic [RW-1:0] hrot_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] held_q, hmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      hswz_o  <= 1'b0;
      hrot_o  <= '0;
      held_q  <= '0;
      hmask_q <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (valid_i) begin
        if (pend_o) begin
          // second half fills only bytes the first half left empty
          data_o  <= held_q | (conv_i & bmask_i & ~hmask_q);
          valid_o <= 1'b1;
          pend_o  <= 1'b0;
        end else if (unal_i) begin
          held_q  <= conv_i & bmask_i;
          hmask_q <= bmask_i;
          hswz_o  <= swz_i;
          hrot_o  <= rot_i;
          pend_o  <= 1'b1;
        end else begin
          data_o  <= conv_i & bmask_i;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dv_mem2reg.sv
module dv_mem2reg #(
  parameter int DATA_W  = 32,
  localparam int NB     = DATA_W / 8,
  localparam int ROT_W  = (NB > 1) ? $clog2(NB) : 1,
  localparam int LANE_W = 2 * NB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              swz_i,
  input  logic              unal_i,
  input  logic [LANE_W-1:0] lanes_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  import dv_pkg::*;

  logic              pend, hswz;
  logic [ROT_W-1:0]  hrot;
  dv_ctl_t           eff;
  logic [DATA_W-1:0] swapped, rotated, bmask;

  // a pending first half owns the controls of the second
  always_comb begin
    eff     = '0;
    eff.swz = pend ? hswz : swz_i;
    eff.rot = 2'(pend ? hrot : rot_i);
  end

  dv_byte_swap #(.NB(NB)) i_swap (
    .swz_i (eff.swz),
    .d_i   (data_i),
    .d_o   (swapped)
  );

  dv_rotate #(.NB(NB)) i_rot (
    .rot_i (ROT_W'(eff.rot)),
    .d_i   (swapped),
    .d_o   (rotated)
  );

  dv_lane_expand #(.NB(NB)) i_lanes (
    .lane_i  (lanes_i[NB-1:0]),
    .bmask_o (bmask)
  );

  dv_merge #(.NB(NB)) i_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .unal_i  (unal_i),
    .swz_i   (swz_i),
    .rot_i   (rot_i),
    .conv_i  (rotated),
    .bmask_i (bmask),
    .pend_o  (pend),
    .hswz_o  (hswz),
    .hrot_o  (hrot),
    .valid_o (valid_o),
    .data_o  (data_o)
  );
endmodule

// File: rtl/dv_mem2reg_chk.sv
module dv_mem2reg_chk #(
  parameter int DATA_W  = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = 2 * NB
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              unal_i,
  input logic [LANE_W-1:0] lanes_i,
  input logic              pend_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] lane_bytes;
  always_comb
    for (int b = 0; b < NB; b++) lane_bytes[8*b +: 8] = {8{lanes_i[b]}};

  always_comb
    if (!rst_ni) assert_reset_quiet_R1: assert (!valid_o && data_o == '0);

  assert_single_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !unal_i && !pend_i |=> valid_o);

  assert_lane_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !unal_i && !pend_i |=> (data_o & ~$past(lane_bytes)) == '0);

  assert_first_half_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && unal_i && !pend_i |=> !valid_o);

  assert_merge_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pend_i |=> valid_o && !pend_i);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

bind dv_mem2reg dv_mem2reg_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .unal_i  (unal_i),
  .lanes_i (lanes_i),
  .pend_i  (pend),
  .valid_o (valid_o),
  .data_o  (data_o)
);

// File: tb/test_dv_mem2reg.sv
module test_dv_mem2reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [1:0]  rot_i = '0;
  logic        swz_i = 1'b0;
  logic        unal_i = 1'b0;
  logic [7:0]  lanes_i = '0;
  logic        valid_o;
  logic [31:0] data_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dv_mem2reg i_dv_mem2reg (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .rot_i(rot_i), .swz_i(swz_i), .unal_i(unal_i), .lanes_i(lanes_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic [31:0] m_conv(logic [31:0] d, logic s, logic [1:0] r);
    logic [31:0] t;
    logic [63:0] w;
    t = s ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    w = {t, t} >> (8 * r);
    return w[31:0];
  endfunction

  function automatic logic [31:0] m_mask(logic [7:0] l);
    return {{8{l[3]}}, {8{l[2]}}, {8{l[1]}}, {8{l[0]}}};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // drive one transfer from a falling edge, return at the next falling edge
  task automatic xfer(logic [31:0] d, logic [1:0] r, logic s, logic u, logic [7:0] l);
    valid_i = 1'b1; data_i = d; rot_i = r; swz_i = s; unal_i = u; lanes_i = l;
    @(negedge clk);
    valid_i = 1'b0; unal_i = 1'b0;
  endtask

  task automatic single(string tag, logic [31:0] d, logic [1:0] r, logic s, logic [7:0] l);
    xfer(d, r, s, 1'b0, l);
    chk({tag, " valid"}, 32'(valid_o), 32'd1);
    chk(tag, data_o, m_conv(d, s, r) & m_mask(l));
  endtask

  task automatic pair(string tag, logic [31:0] d1, logic [1:0] r1, logic s1, logic [7:0] l1,
                      logic [31:0] d2, logic [1:0] r2, logic s2, logic u2, logic [7:0] l2);
    logic [31:0] m1, exp;
    xfer(d1, r1, s1, 1'b1, l1);
    chk("R6 first half silent", 32'(valid_o), 32'd0);
    xfer(d2, r2, s2, u2, l2);
    m1  = m_mask(l1);
    exp = (m_conv(d1, s1, r1) & m1) | (m_conv(d2, s1, r1) & m_mask(l2) & ~m1);
    chk({tag, " valid"}, 32'(valid_o), 32'd1);
    chk(tag, data_o, exp);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h5eed_2024));
    #1;
    chk("R1 reset valid", 32'(valid_o), 32'd0);
    chk("R1 reset data", data_o, 32'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release valid", 32'(valid_o), 32'd0);
    chk("R1 after release data", data_o, 32'd0);

    single("R2 plain", 32'h4433_2211, 2'd0, 1'b0, 8'h0F);
    chk("R2 literal", data_o, 32'h4433_2211);
    single("R4 rot1", 32'h4433_2211, 2'd1, 1'b0, 8'h0F);
    chk("R4 literal", data_o, 32'h1144_3322);
    single("R4 rot3", 32'h4433_2211, 2'd3, 1'b0, 8'h0F);
    chk("R4 literal3", data_o, 32'h3322_1144);
    single("R3 swz", 32'h4433_2211, 2'd0, 1'b1, 8'h0F);
    chk("R3 literal", data_o, 32'h1122_3344);
    single("R3 swz then rot", 32'h4433_2211, 2'd1, 1'b1, 8'h0F);
    chk("R3 literal rot", data_o, 32'h4411_2233);
    single("R5 lanes 0101", 32'hDEAD_BEEF, 2'd0, 1'b0, 8'h05);
    chk("R5 literal", data_o, 32'h00AD_00EF);
    single("R5 upper ignored", 32'hDEAD_BEEF, 2'd2, 1'b1, 8'hF6);
    keep = data_o;
    single("R5 upper ignored b", 32'hDEAD_BEEF, 2'd2, 1'b1, 8'h06);
    chk("R5 upper bits no effect", data_o, keep);

    @(negedge clk);
    chk("R9 idle valid", 32'(valid_o), 32'd0);
    chk("R9 idle data held", data_o, keep);

    pair("R8 merge", 32'h4433_2211, 2'd1, 1'b0, 8'h03,
         32'h8877_6655, 2'd1, 1'b0, 1'b0, 8'h0F);
    pair("R7 second ctl ignored", 32'hA1B2_C3D4, 2'd2, 1'b1, 8'h09,
         32'h0102_0304, 2'd0, 1'b0, 1'b1, 8'h06);
    pair("R8 gap zero", 32'hFFFF_FFFF, 2'd0, 1'b0, 8'h01,
         32'hEEEE_EEEE, 2'd3, 1'b1, 1'b0, 8'h04);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0)
        pair("R8 random pair", $urandom, 2'($urandom), 1'($urandom), 8'($urandom),
             $urandom, 2'($urandom), 1'($urandom), 1'b0, 8'($urandom));
      else
        single("R2 random single", $urandom, 2'($urandom), 1'($urandom), 8'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        keep = data_o;
        @(negedge clk);
        chk("R9 random idle", 32'(valid_o), 32'd0);
        chk("R9 random hold", data_o, keep);
      end
    end
    summary();
  end
endmodule